// File: doc/BRIEF.md
# Memory Controller Reset Sequencer

This block decides what an SDRAM controller does when one of its three reset sources fires. A cold power-on reset puts every flop back to its default value. A soft reset requested by software clears the controller's flops in the same way, over a fixed window, and reports when it has finished. A warm reset keeps the configuration. If software armed the self-refresh-on-warm-reset option beforehand, a warm reset places the memory in a held self-refresh state instead of restarting it. The memory contents then survive until software issues a manual exit command.

The block also holds the memory clock-enable pin high after a cold reset. It keeps it high until software hands it to the controller, and it locks the power-down mode field for as long as that hold lasts. Software reaches the block through a small register port. There are four registers: revision (address 0), control (address 1), status (address 2) and power (address 3). Read data is combinational from the address.

Top module: `mc_reset_seq`

## Requirements
- R1: While `cold_rst` is high at a clock edge, all state returns to defaults. After that edge `ctrl_state` is 0 (idle), `cke_force` is 1, `reset_done` is 1, `pwd_mode` is 0, `ctrl_rst` is 0, and control register bit 4 reads 0.
- R2: Address 0 reads the revision constant `REV_ID` in bits [7:0]. Writes to address 0 do not change it.
- R3: A write to address 1 with bit 1 set, while no soft reset is running, starts a soft reset. From the next edge, `ctrl_rst` is 1, status bit 0 (`reset_done`) is 0 and control bit 1 reads 1. Exactly 4 edges after the request edge, `reset_done` returns to 1, `ctrl_rst` returns to 0 and control bit 1 clears by itself.
- R4: A soft reset clears the self-refresh-on-warm flag (control bit 4) and `pwd_mode`, and holds `ctrl_state` at idle. It does not re-assert `cke_force`.
- R5: A warm reset with control bit 4 set moves `ctrl_state` to 1 (self-refresh held) at that edge. All register contents are kept.
- R6: A warm reset with control bit 4 clear moves `ctrl_state` to idle at that edge. All register contents are kept.
- R7: The self-refresh held state persists until `sr_exit_cmd` is high at an edge. That edge moves `ctrl_state` to 2 (normal).
- R8: `sr_exit_cmd` has no effect when `ctrl_state` is not self-refresh held.
- R9: Writing 1 to power register bit 0 clears `cke_force`. Only a cold reset sets it again. From idle, the first edge that sees `cke_force` low moves `ctrl_state` to normal.
- R10: A write to power register bits [3:2] (the `pwd_mode` field) is ignored while `cke_force` is 1.
- R11: `ctrl_state` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Power-on reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset request, active high |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| sr_exit_cmd | input | 1 | Manual self-refresh exit command |
| ctrl_state | output | 2 | 0 idle, 1 self-refresh held, 2 normal |
| ctrl_rst | output | 1 | Controller flops held in soft reset |
| reset_done | output | 1 | Reset complete |
| cke_force | output | 1 | Clock-enable pin forced high |
| pwd_mode | output | 2 | Power-down mode field |

## Verification
Some properties can be checked on every cycle, and the checker does so. These are: a legal state encoding, `reset_done` low only while `ctrl_rst` is high, the clock-enable hold never returning without a cold reset, `pwd_mode` frozen under the hold, and the held and normal states being left only for their permitted causes. Other behaviour is cumulative: the exact four-edge soft reset window, retention of registers across a warm reset, the self-clearing request bit and the revision readback. Only the bench's sequences show these, by reading the registers back and counting edges.

// File: rtl/mc_rst_pkg.sv
package mc_rst_pkg;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;
    localparam int PWD_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SR_HELD = 2'd1,
        ST_NORMAL  = 2'd2
    } mc_state_e;

    localparam logic [ADDR_W-1:0] ADDR_REV  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_PWR  = 2'd3;

    localparam int CTRL_SOFT_BIT = 1;
    localparam int CTRL_SRW_BIT  = 4;
    localparam int STAT_DONE_BIT = 0;
    localparam int PWR_REL_BIT   = 0;
    localparam int PWR_PWD_LSB   = 2;

    typedef struct packed {
        logic             sr_on_warm;
        logic             cke_released;
        logic [PWD_W-1:0] pwd;
    } mc_cfg_t;

    function automatic mc_cfg_t cfg_default();
        mc_cfg_t c;
        c.sr_on_warm   = 1'b0;
        c.cke_released = 1'b0;
        c.pwd          = '0;
        return c;
    endfunction

    function automatic logic soft_req_hit(input logic wr, input logic [ADDR_W-1:0] a,
                                          input logic [DATA_W-1:0] d);
        return wr && (a == ADDR_CTRL) && d[CTRL_SOFT_BIT];
    endfunction

endpackage

// File: rtl/mc_rst_softctl.sv
module mc_rst_softctl
    import mc_rst_pkg::*;
#(
    parameter int SOFT_CYCLES = 4
) (
    input  logic clk,
    input  logic cold_rst,
    input  logic soft_start,
    output logic soft_busy,
    output logic done
);
    localparam int CNT_W = $clog2(SOFT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SOFT_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            soft_busy <= 1'b0;
            done      <= 1'b1;
            cnt       <= '0;
        end else if (soft_start) begin
            soft_busy <= 1'b1;
            done      <= 1'b0;
            cnt       <= '0;
        end else if (soft_busy) begin
            if (cnt == LAST) begin
                soft_busy <= 1'b0;
                done      <= 1'b1;
                cnt       <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mc_rst_regs.sv
module mc_rst_regs
    import mc_rst_pkg::*;
#(
    parameter logic [DATA_W-1:0] REV_ID = 8'h3A
) (
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              soft_busy,
    input  logic              done,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              soft_start,
    output mc_cfg_t           cfg
);
    always_comb soft_start = soft_req_hit(wr_en, addr, wdata) && !soft_busy;

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            cfg <= cfg_default();
        end else if (soft_start || soft_busy) begin
            cfg.sr_on_warm <= 1'b0;
            cfg.pwd        <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_CTRL: cfg.sr_on_warm <= wdata[CTRL_SRW_BIT];
                ADDR_PWR: begin
                    if (wdata[PWR_REL_BIT]) cfg.cke_released <= 1'b1;
                    if (cfg.cke_released)
                        cfg.pwd <= wdata[PWR_PWD_LSB +: PWD_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_REV:  rdata = REV_ID;
            ADDR_CTRL: begin
                rdata[CTRL_SOFT_BIT] = soft_busy;
                rdata[CTRL_SRW_BIT]  = cfg.sr_on_warm;
            end
            ADDR_STAT: rdata[STAT_DONE_BIT] = done;
            ADDR_PWR: begin
                rdata[PWR_REL_BIT]              = cfg.cke_released;
                rdata[PWR_PWD_LSB +: PWD_W]     = cfg.pwd;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/mc_rst_fsm.sv
module mc_rst_fsm
    import mc_rst_pkg::*;
(
    input  logic      clk,
    input  logic      cold_rst,
    input  logic      warm_rst,
    input  logic      soft_start,
    input  logic      soft_busy,
    input  logic      sr_on_warm,
    input  logic      cke_force,
    input  logic      exit_cmd,
    output mc_state_e state
);
    mc_state_e nxt;

    always_comb begin
        nxt = state;
        if (soft_start || soft_busy) begin
            nxt = ST_IDLE;
        end else if (warm_rst) begin
            nxt = sr_on_warm ? ST_SR_HELD : ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:    if (!cke_force) nxt = ST_NORMAL;
                ST_SR_HELD: if (exit_cmd)   nxt = ST_NORMAL;
                ST_NORMAL:  nxt = ST_NORMAL;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (cold_rst) state <= ST_IDLE;
        else          state <= nxt;
    end
endmodule

// File: rtl/mc_reset_seq.sv
module mc_reset_seq
    import mc_rst_pkg::*;
#(
    parameter logic [7:0] REV_ID      = 8'h3A,
    parameter int         SOFT_CYCLES = 4
) (
    input  logic       clk,
    input  logic       cold_rst,
    input  logic       warm_rst,
    input  logic       cfg_wr_en,
    input  logic [1:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       sr_exit_cmd,
    output logic [1:0] ctrl_state,
    output logic       ctrl_rst,
    output logic       reset_done,
    output logic       cke_force,
    output logic [1:0] pwd_mode
);
    logic      soft_start;
    logic      soft_busy;
    logic      done;
    mc_cfg_t   cfg;
    mc_state_e state;

    mc_rst_softctl #(.SOFT_CYCLES(SOFT_CYCLES)) u_soft (
        .clk        (clk),
        .cold_rst   (cold_rst),
        .soft_start (soft_start),
        .soft_busy  (soft_busy),
        .done       (done)
    );

    mc_rst_regs #(.REV_ID(REV_ID)) u_regs (
        .clk        (clk),
        .cold_rst   (cold_rst),
        .soft_busy  (soft_busy),
        .done       (done),
        .wr_en      (cfg_wr_en),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .soft_start (soft_start),
        .cfg        (cfg)
    );

    mc_rst_fsm u_fsm (
        .clk        (clk),
        .cold_rst   (cold_rst),
        .warm_rst   (warm_rst),
        .soft_start (soft_start),
        .soft_busy  (soft_busy),
        .sr_on_warm (cfg.sr_on_warm),
        .cke_force  (cke_force),
        .exit_cmd   (sr_exit_cmd),
        .state      (state)
    );

    assign ctrl_state = state;
    assign ctrl_rst   = soft_busy;
    assign reset_done = done;
    assign cke_force  = !cfg.cke_released;
    assign pwd_mode   = cfg.pwd;
endmodule

// File: rtl/mc_reset_seq_chk.sv
module mc_reset_seq_chk (
    input logic       clk,
    input logic       cold_rst,
    input logic       warm_rst,
    input logic       cfg_wr_en,
    input logic [1:0] cfg_addr,
    input logic [7:0] cfg_wdata,
    input logic       sr_exit_cmd,
    input logic [1:0] ctrl_state,
    input logic       ctrl_rst,
    input logic       reset_done,
    input logic       cke_force,
    input logic [1:0] pwd_mode
);
    logic soft_wr;
    assign soft_wr = cfg_wr_en && (cfg_addr == 2'd1) && cfg_wdata[1];

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (cold_rst)
        ctrl_state != 2'd3);  // R11

    AST_DONE_LOW_ONLY_IN_SOFT: assert property (@(posedge clk) disable iff (cold_rst)
        !reset_done |-> ctrl_rst);  // R3

    AST_SOFT_END_DONE: assert property (@(posedge clk) disable iff (cold_rst)
        $fell(ctrl_rst) |-> reset_done);  // R3

    AST_CKE_NO_REFORCE: assert property (@(posedge clk) disable iff (cold_rst)
        !cke_force |=> !cke_force);  // R9

    AST_PWD_LOCKED: assert property (@(posedge clk) disable iff (cold_rst)
        (cke_force && !ctrl_rst && !soft_wr) |=> $stable(pwd_mode));  // R10

    AST_SR_HELD_KEEPS: assert property (@(posedge clk) disable iff (cold_rst)
        (ctrl_state == 2'd1 && !sr_exit_cmd && !warm_rst && !soft_wr && !ctrl_rst)
        |=> ctrl_state == 2'd1);  // R7

    AST_NORMAL_IGNORES_EXIT: assert property (@(posedge clk) disable iff (cold_rst)
        (ctrl_state == 2'd2 && !warm_rst && !soft_wr && !ctrl_rst)
        |=> ctrl_state == 2'd2);  // R8

    AST_SOFT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (cold_rst)
        ctrl_rst |-> ctrl_state == 2'd0);  // R4
endmodule

bind mc_reset_seq mc_reset_seq_chk u_chk (
    .clk         (clk),
    .cold_rst    (cold_rst),
    .warm_rst    (warm_rst),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .sr_exit_cmd (sr_exit_cmd),
    .ctrl_state  (ctrl_state),
    .ctrl_rst    (ctrl_rst),
    .reset_done  (reset_done),
    .cke_force   (cke_force),
    .pwd_mode    (pwd_mode)
);

// File: tb/sim_mc_reset_seq.sv
module sim_mc_reset_seq;
    localparam logic [7:0] REV = 8'h3A;

    logic       clk = 1'b0;
    logic       cold_rst = 1'b1;
    logic       warm_rst = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic [7:0] cfg_rdata;
    logic       sr_exit_cmd = 1'b0;
    logic [1:0] ctrl_state;
    logic       ctrl_rst;
    logic       reset_done;
    logic       cke_force;
    logic [1:0] pwd_mode;

    always #5 clk = ~clk;

    mc_reset_seq #(.REV_ID(REV), .SOFT_CYCLES(4)) u0 (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sr_exit_cmd(sr_exit_cmd),
        .ctrl_state(ctrl_state), .ctrl_rst(ctrl_rst), .reset_done(reset_done),
        .cke_force(cke_force), .pwd_mode(pwd_mode)
    );

    typedef enum int {O_STATE, O_CKE, O_DONE, O_PWD, O_CRST, O_RDATA} obs_e;
    typedef struct {
        string tag;
        obs_e  sel;
        int    val;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    function automatic int observe(obs_e s);
        case (s)
            O_STATE: return int'(ctrl_state);
            O_CKE:   return int'(cke_force);
            O_DONE:  return int'(reset_done);
            O_PWD:   return int'(pwd_mode);
            O_CRST:  return int'(ctrl_rst);
            default: return int'(cfg_rdata);
        endcase
    endfunction

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            int act;
            it = q.pop_front();
            act = observe(it.sel);
            checks++;
            if (act !== it.val) begin
                errors++;
                $display("FAIL %s sel=%s actual=%0h expected=%0h", it.tag, it.sel.name(), act, it.val);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic expect_v(string tag, obs_e s, int v);
        item_t it;
        it.tag = tag; it.sel = s; it.val = v;
        q.push_back(it);
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        cyc();
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(string tag, logic [1:0] a, int v);
        cfg_addr = a;
        expect_v(tag, O_RDATA, v);
    endtask

    initial begin
        cyc(); cyc();
        // R1 reset defaults
        expect_v("R1", O_STATE, 0);
        expect_v("R1", O_CKE, 1);
        expect_v("R1", O_DONE, 1);
        expect_v("R1", O_PWD, 0);
        expect_v("R1", O_CRST, 0);
        rd("R1", 2'd1, 8'h00);
        cold_rst = 1'b0;
        cyc();

        // R2 revision, write ignored
        rd("R2", 2'd0, REV);
        cyc();
        wr(2'd0, 8'hFF);
        rd("R2", 2'd0, REV);
        cyc();

        // R10 pwd write ignored while forced
        wr(2'd3, 8'h0C);
        expect_v("R10", O_PWD, 0);
        expect_v("R10", O_CKE, 1);
        cyc();
        expect_v("R9", O_STATE, 0);

        // R9 release
        wr(2'd3, 8'h01);
        expect_v("R9", O_CKE, 0);
        expect_v("R9", O_STATE, 0);
        cyc();
        expect_v("R9", O_STATE, 2);
        wr(2'd3, 8'h09);
        expect_v("R10", O_PWD, 2);
        rd("R9", 2'd3, 8'h09);
        cyc();

        // R8 exit in normal ignored
        sr_exit_cmd = 1'b1;
        cyc();
        sr_exit_cmd = 1'b0;
        expect_v("R8", O_STATE, 2);
        expect_v("R8", O_PWD, 2);

        // R5 warm with flag
        wr(2'd1, 8'h10);
        rd("R5", 2'd1, 8'h10);
        warm_rst = 1'b1;
        cyc();
        warm_rst = 1'b0;
        expect_v("R5", O_STATE, 1);
        expect_v("R5", O_PWD, 2);
        expect_v("R5", O_CKE, 0);
        rd("R5", 2'd1, 8'h10);

        // R7 held until exit
        cyc(); cyc(); cyc();
        expect_v("R7", O_STATE, 1);
        sr_exit_cmd = 1'b1;
        cyc();
        sr_exit_cmd = 1'b0;
        expect_v("R7", O_STATE, 2);

        // R6 warm without flag
        wr(2'd1, 8'h00);
        warm_rst = 1'b1;
        cyc();
        warm_rst = 1'b0;
        expect_v("R6", O_STATE, 0);
        expect_v("R6", O_PWD, 2);
        rd("R6", 2'd3, 8'h09);
        cyc();
        expect_v("R6", O_STATE, 2);
        wr(2'd1, 8'h10);

        // R3 / R4 soft reset window
        wr(2'd1, 8'h12);
        expect_v("R3", O_CRST, 1);
        expect_v("R3", O_DONE, 0);
        expect_v("R4", O_STATE, 0);
        rd("R3", 2'd1, 8'h02);
        cyc();
        rd("R3", 2'd2, 8'h00);
        cyc();
        expect_v("R3", O_DONE, 0);
        cyc();
        expect_v("R3", O_DONE, 0);
        expect_v("R3", O_CRST, 1);
        cyc();
        expect_v("R3", O_DONE, 1);
        expect_v("R3", O_CRST, 0);
        rd("R3", 2'd1, 8'h00);
        expect_v("R4", O_PWD, 0);
        expect_v("R4", O_CKE, 0);
        expect_v("R4", O_STATE, 0);
        cyc();
        expect_v("R9", O_STATE, 2);
        rd("R3", 2'd2, 8'h01);

        // R1 cold reset again
        cyc();
        cold_rst = 1'b1;
        cyc();
        cold_rst = 1'b0;
        expect_v("R1", O_CKE, 1);
        expect_v("R1", O_STATE, 0);
        expect_v("R1", O_PWD, 0);
        cyc(); cyc();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule